// File: doc/BRIEF.md
# Lockable Byte-Bus Watchdog Timer

This block is a watchdog timer for a small board-control device. Software reaches it through a byte-wide register bus with a two-bit address, write data, a write strobe, a read strobe and registered read data. It holds a control byte, a timeout byte counted in whole seconds, and a kick location. A write of the magic byte 0x6b to the kick location reloads the countdown from the timeout byte. A one-second tick input drives the countdown. When the countdown reaches zero while the watchdog is armed, the block latches an expired state. It then raises the system-reset output, the dedicated timeout output, or both, according to two select bits.

Software arms the watchdog in this order: clear both enables, write the timeout, kick, then set one enable bit together with the lock and output-select bits. Two enable bits select normal or recovery operation, and recovery wins when both are set. A lock bit freezes the control and timeout bytes until a hardware reset, but kicks still work when locked. A timeout of zero, a kick and an enable make the watchdog expire at once, which gives software a way to request expiry immediately.

Top module: `wdt_lockable`

## Requirements
- R1: After reset the control byte reads 0x00, the timeout byte reads 0x1E (parameter default), the countdown reads 0x1E, and all three outputs are low.
- R2: Addresses: 0 = control, 1 = timeout, 2 = kick (reads back the current countdown), 3 = status (read-only). A read strobe loads bus_rdata_o at the next clock edge with the value held before that edge. The control byte keeps only bits 0, 1, 2, 6 and 7, and its other bits read as 0.
- R3: Writing 0x6b to address 2 loads the countdown from the timeout byte at the next edge.
- R4: Writing any other value to address 2 leaves the countdown unchanged.
- R5: While control bit 0 or bit 1 is set and the block has not expired, each cycle with the tick high decrements a nonzero countdown by one.
- R6: While control bits 0 and 1 are both clear, the countdown holds and the block never expires.
- R7: When the watchdog is armed, has not expired and its countdown is zero, it expires at the next edge with no tick needed. With timeout 0, a kick and an enable, this makes it fire immediately.
- R8: On expiry, sys_rst_o rises if control bit 6 is set and wdt_tmo_o rises if control bit 7 is set. Each output stays high until reset, and neither output is high unless the block has expired.
- R9: Once control bit 2 (lock) is set, writes to the control and timeout bytes are ignored until reset, while kicks still reload the countdown.
- R10: Status bit 0 and mode_rec_o show that recovery mode is selected, which is the case when control bit 1 is set, whether or not bit 0 is also set. Status bit 1 shows the expired state.
- R11: A valid kick takes priority over a tick in the same cycle. A kick in a cycle where an armed countdown is zero prevents expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1s_i | input | 1 | One-cycle pulse each second |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Registered read data |
| sys_rst_o | output | 1 | Expiry request for system reset |
| wdt_tmo_o | output | 1 | Dedicated expiry indication |
| mode_rec_o | output | 1 | Recovery mode selected |

## Verification
A valid kick can fall in the same cycle as a tick, and in the same cycle as the zero-count expiry decision. Directed steps drive a kick together with a tick, and also kick exactly when an armed countdown has reached zero. In both cases the bench requires the countdown to read back the full timeout, with no expiry flag and no output asserted. The random phase keeps timeouts small and ticks frequent, so that these coincidences recur often. A cycle-level model in the bench judges every one of them.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int REG_AW = 2;

  typedef enum logic [REG_AW-1:0] {
    REG_CTRL = 2'd0,
    REG_TMO  = 2'd1,
    REG_KICK = 2'd2,
    REG_STAT = 2'd3
  } reg_sel_e;

  localparam int CB_EN_NORM = 0;
  localparam int CB_EN_REC  = 1;
  localparam int CB_LOCK    = 2;
  localparam int CB_RST_SEL = 6;
  localparam int CB_TMO_SEL = 7;

  localparam logic [7:0] CTRL_KEEP = 8'hC7;

  localparam int SB_REC = 0;
  localparam int SB_EXP = 1;
endpackage

// File: rtl/wdt_regfile.sv
module wdt_regfile
  import wdt_pkg::*;
#(
  parameter int          DATA_W    = 8,
  parameter logic [7:0]  TMO_RESET = 8'd30,
  parameter logic [7:0]  KICK_CODE = 8'h6b
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] cnt_i,
  input  logic              expired_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] tmo_o,
  output logic              kick_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] ctrl_q, tmo_q, rdata_q, rd_mux, stat_w;
  logic              cfg_open;

  assign cfg_open = !ctrl_q[CB_LOCK];
  assign kick_o   = wr_en_i && (addr_i == REG_KICK) && (wdata_i == KICK_CODE);

  always_comb begin
    stat_w         = '0;
    stat_w[SB_REC] = ctrl_q[CB_EN_REC];
    stat_w[SB_EXP] = expired_i;
  end

  always_comb begin
    case (addr_i)
      REG_CTRL: rd_mux = ctrl_q;
      REG_TMO:  rd_mux = tmo_q;
      REG_KICK: rd_mux = cnt_i;
      default:  rd_mux = stat_w;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      tmo_q   <= DATA_W'(TMO_RESET);
      rdata_q <= '0;
    end else begin
      if (wr_en_i && cfg_open) begin
        if (addr_i == REG_CTRL) ctrl_q <= wdata_i & DATA_W'(CTRL_KEEP);
        if (addr_i == REG_TMO)  tmo_q  <= wdata_i;
      end
      if (rd_en_i) rdata_q <= rd_mux;
    end
  end

  assign ctrl_o  = ctrl_q;
  assign tmo_o   = tmo_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int               CNT_W     = 8,
  parameter logic [CNT_W-1:0] CNT_RESET = 8'd30
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             kick_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             enable_i,
  input  logic             rst_sel_i,
  input  logic             tmo_sel_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expired_o,
  output logic             sys_rst_o,
  output logic             tmo_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             exp_q, srst_q, tout_q;
  logic             at_zero, running, fire;

  assign at_zero = (cnt_q == '0);
  assign running = enable_i && !exp_q;
  assign fire    = running && at_zero && !kick_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= CNT_RESET;
      exp_q  <= 1'b0;
      srst_q <= 1'b0;
      tout_q <= 1'b0;
    end else begin
      if (kick_i)
        cnt_q <= reload_i;
      else if (running && tick_i && !at_zero)
        cnt_q <= cnt_q - 1'b1;
      if (fire) begin
        exp_q <= 1'b1;
        if (rst_sel_i) srst_q <= 1'b1;
        if (tmo_sel_i) tout_q <= 1'b1;
      end
    end
  end

  assign cnt_o     = cnt_q;
  assign expired_o = exp_q;
  assign sys_rst_o = srst_q;
  assign tmo_o     = tout_q;
endmodule

// File: rtl/wdt_lockable.sv
module wdt_lockable
  import wdt_pkg::*;
#(
  parameter int         DATA_W    = 8,
  parameter logic [7:0] TMO_RESET = 8'd30,
  parameter logic [7:0] KICK_CODE = 8'h6b
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1s_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [1:0]        bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              sys_rst_o,
  output logic              wdt_tmo_o,
  output logic              mode_rec_o
);
  localparam int CNT_W = DATA_W;

  logic [DATA_W-1:0] ctrl_q, tmo_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              kick_w, expired_q, armed_w;

  assign armed_w = ctrl_q[CB_EN_NORM] || ctrl_q[CB_EN_REC];

  wdt_regfile #(
    .DATA_W   (DATA_W),
    .TMO_RESET(TMO_RESET),
    .KICK_CODE(KICK_CODE)
  ) regs_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en_i  (bus_wr_i),
    .rd_en_i  (bus_rd_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .cnt_i    (cnt_q),
    .expired_i(expired_q),
    .ctrl_o   (ctrl_q),
    .tmo_o    (tmo_q),
    .kick_o   (kick_w),
    .rdata_o  (bus_rdata_o)
  );

  wdt_countdown #(
    .CNT_W    (CNT_W),
    .CNT_RESET(CNT_W'(TMO_RESET))
  ) cnt_i (
    .clk      (clk),
    .rst      (rst),
    .tick_i   (tick_1s_i),
    .kick_i   (kick_w),
    .reload_i (tmo_q),
    .enable_i (armed_w),
    .rst_sel_i(ctrl_q[CB_RST_SEL]),
    .tmo_sel_i(ctrl_q[CB_TMO_SEL]),
    .cnt_o    (cnt_q),
    .expired_o(expired_q),
    .sys_rst_o(sys_rst_o),
    .tmo_o    (wdt_tmo_o)
  );

  assign mode_rec_o = ctrl_q[CB_EN_REC];
endmodule

// File: rtl/wdt_lockable_chk.sv
module wdt_lockable_chk #(
  parameter int         DATA_W    = 8,
  parameter logic [7:0] KICK_CODE = 8'h6b
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              wr,
  input logic [1:0]        addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] ctrl,
  input logic [DATA_W-1:0] tmo,
  input logic [DATA_W-1:0] cnt,
  input logic              expired,
  input logic              srst,
  input logic              tout
);
  logic good_kick, bad_kick, armed;
  assign good_kick = wr && addr == 2'd2 && wdata == DATA_W'(KICK_CODE);
  assign bad_kick  = wr && addr == 2'd2 && wdata != DATA_W'(KICK_CODE);
  assign armed     = ctrl[0] || ctrl[1];

  assert_kick_reload_R3: assert property (@(posedge clk) disable iff (rst)
    good_kick |=> cnt == $past(tmo));
  assert_bad_kick_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    (bad_kick && !tick) |=> $stable(cnt));
  assert_tick_step_R5: assert property (@(posedge clk) disable iff (rst)
    (armed && !expired && cnt != '0 && tick && !good_kick) |=> cnt == $past(cnt) - 1'b1);
  assert_idle_no_fire_R6: assert property (@(posedge clk) disable iff (rst)
    (!armed && !expired) |=> !expired);
  assert_zero_fires_R7: assert property (@(posedge clk) disable iff (rst)
    (armed && cnt == '0 && !good_kick) |=> expired);
  assert_rst_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    srst |=> srst);
  assert_tmo_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    tout |=> tout);
  assert_out_needs_exp_R8: assert property (@(posedge clk) disable iff (rst)
    (srst || tout) |-> expired);
  assert_lock_ctrl_R9: assert property (@(posedge clk) disable iff (rst)
    (ctrl[2] && wr && addr == 2'd0) |=> $stable(ctrl));
  assert_lock_tmo_R9: assert property (@(posedge clk) disable iff (rst)
    (ctrl[2] && wr && addr == 2'd1) |=> $stable(tmo));
  assert_kick_beats_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (armed && !expired && good_kick) |=> !expired);
endmodule

bind wdt_lockable wdt_lockable_chk #(
  .DATA_W   (DATA_W),
  .KICK_CODE(KICK_CODE)
) chk_i (
  .clk    (clk),
  .rst    (rst),
  .tick   (tick_1s_i),
  .wr     (bus_wr_i),
  .addr   (bus_addr_i),
  .wdata  (bus_wdata_i),
  .ctrl   (ctrl_q),
  .tmo    (tmo_q),
  .cnt    (cnt_q),
  .expired(expired_q),
  .srst   (sys_rst_o),
  .tout   (wdt_tmo_o)
);

// File: tb/wdt_lockable_tb.sv
`timescale 1ns/1ps
module wdt_lockable_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       srst, tout, mrec;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  logic [7:0] m_ctrl, m_tmo, m_cnt, m_rd;
  logic       m_exp, m_srst, m_tout;

  always #5 clk = ~clk;

  wdt_lockable dut_i (
    .clk(clk), .rst(rst), .tick_1s_i(tick), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .sys_rst_o(srst), .wdt_tmo_o(tout), .mode_rec_o(mrec)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rd_model(logic [1:0] a);
    case (a)
      2'd0: return m_ctrl;
      2'd1: return m_tmo;
      2'd2: return m_cnt;
      default: return {6'b0, m_exp, m_ctrl[1]};
    endcase
  endfunction

  task automatic model_reset();
    m_ctrl = 8'h00; m_tmo = 8'h1E; m_cnt = 8'h1E; m_rd = 8'h00;
    m_exp = 1'b0; m_srst = 1'b0; m_tout = 1'b0;
  endtask

  task automatic auto_chk();
    chk("R2 read data", rdata, m_rd);
    chk("R8 sys_rst", {7'b0, srst}, {7'b0, m_srst});
    chk("R8 timeout out", {7'b0, tout}, {7'b0, m_tout});
    chk("R10 mode_rec", {7'b0, mrec}, {7'b0, m_ctrl[1]});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr = 0; rd = 0; tick = 0;
    @(posedge clk); #1;
    model_reset();
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic step(bit w, bit r, logic [1:0] a, logic [7:0] d, bit tk);
    logic [7:0] n_ctrl, n_tmo, n_cnt, n_rd;
    logic n_exp, n_srst, n_tout, kick, armed;
    @(negedge clk);
    wr = w; rd = r; addr = a; wdata = d; tick = tk;
    kick  = w && a == 2'd2 && d == 8'h6b;
    armed = m_ctrl[0] | m_ctrl[1];
    n_ctrl = m_ctrl; n_tmo = m_tmo; n_cnt = m_cnt; n_rd = m_rd;
    n_exp = m_exp; n_srst = m_srst; n_tout = m_tout;
    if (w && !m_ctrl[2] && a == 2'd0) n_ctrl = d & 8'hC7;
    if (w && !m_ctrl[2] && a == 2'd1) n_tmo = d;
    if (kick) n_cnt = m_tmo;
    else if (armed && !m_exp && tk && m_cnt != 0) n_cnt = m_cnt - 8'd1;
    if (armed && !m_exp && m_cnt == 0 && !kick) begin
      n_exp = 1'b1;
      if (m_ctrl[6]) n_srst = 1'b1;
      if (m_ctrl[7]) n_tout = 1'b1;
    end
    if (r) n_rd = rd_model(a);
    @(posedge clk); #1;
    m_ctrl = n_ctrl; m_tmo = n_tmo; m_cnt = n_cnt; m_rd = n_rd;
    m_exp = n_exp; m_srst = n_srst; m_tout = n_tout;
    auto_chk();
  endtask

  task automatic rd_chk(logic [1:0] a, logic [7:0] exp, string tag);
    step(0, 1, a, 8'h00, 0);
    chk(tag, rdata, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (2) @(posedge clk);
    do_reset();
    // R1 reset state
    chk("R1 sys_rst", {7'b0, srst}, 8'h0);
    chk("R1 timeout out", {7'b0, tout}, 8'h0);
    rd_chk(2'd0, 8'h00, "R1 ctrl");
    rd_chk(2'd1, 8'h1E, "R1 timeout");
    rd_chk(2'd2, 8'h1E, "R1 count");
    // R2 field mask and readback
    step(1, 0, 2'd0, 8'h38, 0);
    rd_chk(2'd0, 8'h00, "R2 unused bits");
    step(1, 0, 2'd1, 8'h05, 0);
    rd_chk(2'd1, 8'h05, "R2 timeout");
    // R3 kick reload
    step(1, 0, 2'd2, 8'h6b, 0);
    rd_chk(2'd2, 8'h05, "R3 reload");
    // R4 bad kick ignored
    step(1, 0, 2'd1, 8'h09, 0);
    step(1, 0, 2'd2, 8'h6a, 0);
    rd_chk(2'd2, 8'h05, "R4 bad kick");
    // R6 disabled: ticks do nothing
    repeat (4) step(0, 0, 2'd0, 8'h00, 1);
    rd_chk(2'd2, 8'h05, "R6 count held");
    rd_chk(2'd3, 8'h00, "R6 not expired");
    // R5 counting in normal mode with reset select
    step(1, 0, 2'd1, 8'h05, 0);
    step(1, 0, 2'd2, 8'h6b, 0);
    step(1, 0, 2'd0, 8'h41, 0);
    repeat (4) step(0, 0, 2'd0, 8'h00, 1);
    rd_chk(2'd2, 8'h01, "R5 count after 4 ticks");
    chk("R5 no early expiry", {7'b0, srst}, 8'h0);
    step(0, 0, 2'd0, 8'h00, 1);
    rd_chk(2'd2, 8'h00, "R5 count zero");
    chk("R8 sys_rst raised", {7'b0, srst}, 8'h1);
    chk("R8 timeout out not selected", {7'b0, tout}, 8'h0);
    step(1, 0, 2'd0, 8'h00, 0);
    step(0, 0, 2'd0, 8'h00, 0);
    chk("R8 sys_rst sticky", {7'b0, srst}, 8'h1);
    // R7 fire now in recovery mode with timeout output
    do_reset();
    step(1, 0, 2'd1, 8'h00, 0);
    step(1, 0, 2'd2, 8'h6b, 0);
    step(1, 0, 2'd0, 8'h82, 0);
    step(0, 0, 2'd0, 8'h00, 0);
    chk("R7 fire now", {7'b0, tout}, 8'h1);
    chk("R7 reset out not selected", {7'b0, srst}, 8'h0);
    rd_chk(2'd3, 8'h03, "R10 status rec+expired");
    // R10 both enables: recovery wins
    do_reset();
    step(1, 0, 2'd0, 8'h03, 0);
    chk("R10 mode_rec both", {7'b0, mrec}, 8'h1);
    rd_chk(2'd3, 8'h01, "R10 status both");
    // R9 lock
    do_reset();
    step(1, 0, 2'd1, 8'h03, 0);
    step(1, 0, 2'd2, 8'h6b, 0);
    step(1, 0, 2'd0, 8'h05, 0);
    step(1, 0, 2'd0, 8'h00, 0);
    rd_chk(2'd0, 8'h05, "R9 ctrl locked");
    step(1, 0, 2'd1, 8'h07, 0);
    rd_chk(2'd1, 8'h03, "R9 timeout locked");
    repeat (2) step(0, 0, 2'd0, 8'h00, 1);
    rd_chk(2'd2, 8'h01, "R9 counting");
    step(1, 0, 2'd2, 8'h6b, 0);
    rd_chk(2'd2, 8'h03, "R9 kick while locked");
    // R11 kick with tick, kick at zero
    step(1, 0, 2'd2, 8'h6b, 1);
    rd_chk(2'd2, 8'h03, "R11 kick beats tick");
    repeat (3) step(0, 0, 2'd0, 8'h00, 1);
    step(1, 0, 2'd2, 8'h6b, 0);
    rd_chk(2'd3, 8'h00, "R11 kick at zero no expiry");
    rd_chk(2'd2, 8'h03, "R11 reloaded");
    // Random phase against the model
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      int op;
      logic [7:0] d;
      op = $urandom_range(0, 9);
      if ((m_exp && $urandom_range(0, 30) == 0) || $urandom_range(0, 300) == 0) begin
        do_reset();
        continue;
      end
      d = $urandom;
      case (op)
        0, 1: begin
          if ($urandom_range(0, 40) != 0) d[2] = 1'b0;
          step(1, $urandom_range(0, 1), 2'($urandom_range(0, 3)), d, $urandom_range(0, 2) == 0);
          // address randomness above may hit any register
        end
        2: step(1, 0, 2'd1, 8'($urandom_range(0, 6)), $urandom_range(0, 2) == 0);
        3, 4: step(1, $urandom_range(0, 1), 2'd2, 8'h6b, $urandom_range(0, 2) == 0);
        5: step(1, 0, 2'd2, d, $urandom_range(0, 2) == 0);
        6: step(1, 0, 2'd0, {d[7:6], 5'b0, d[0]} | 8'h02, 1'b1);
        default: step(0, $urandom_range(0, 1), 2'($urandom_range(0, 3)), d, $urandom_range(0, 2) == 0);
      endcase
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule